// File: doc/BRIEF.md
# Warp Load Coalescer

The coalescer accepts one load request for a whole warp of 32 lanes. Each lane carries an active flag, a byte address and an access size from 1 to 16 bytes. The block reduces these accesses to the smallest set of distinct aligned memory segments that covers every byte any active lane needs. The segment size is chosen per request as either 32 or 128 bytes.

It then emits one request per distinct segment, one per cycle, over a valid/ready stream. Each request carries the segment base address and a 32-bit mask of the lanes that the segment serves. A whole segment is fetched even when a lane needs only one byte of it. After the last segment has been handed over, a one-cycle done strobe reports how many segments were issued. Only then does the block accept the next warp.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `reqReady` is 1. A warp is taken in a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the following cycle until the cycle after the done strobe.
- R2: `segSel` = 0 selects 32-byte segments and `segSel` = 1 selects 128-byte segments. Every emitted `outBase` is a lane address with its low 5 (or 7) bits cleared. All warp inputs are sampled only in the accepting cycle.
- R3: Each distinct segment touched by an active lane is emitted exactly once, and `doneCount` never exceeds twice the lane count.
- R4: A lane whose segment no other lane shares still produces a full segment request, even for a 1-byte access.
- R5: Lane `i` reads bytes `addr` through `addr + code`, where `code` is the 4-bit field `reqSizeM1[4i+3:4i]` (size = code + 1). A lane whose last byte falls in a different segment from its first byte touches both segments. A lane that ends exactly on the last byte of a segment touches only that one.
- R6: Segments are emitted in the order of the lowest-numbered active lane that touches them. Within one lane, the segment holding its first byte comes before the segment holding its last byte.
- R7: `outMask` bit `i` is 1 exactly when active lane `i` touches the emitted segment, fully or in part. The mask is never zero while `outValid` is 1.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid`, `outBase` and `outMask` hold their values into the next cycle.
- R9: A warp with no active lanes produces no segment request. `donePulse` is 1 with `doneCount` = 0 in the cycle after acceptance.
- R10: `donePulse` is 1 for one cycle, in the cycle after the last segment handshake, with `doneCount` equal to the number of segments issued. It is never 1 while `outValid` is 1.
- R11: Inactive lanes contribute no segments, and their mask bits are always 0.
- R12: 32 active lanes making contiguous 4-byte loads from an aligned base need four 32-byte segments, or one 128-byte segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Warp request present |
| reqReady | output | 1 | Block can take a warp |
| reqActive | input | 32 | Per-lane active flags |
| reqAddr | input | 1024 | Per-lane byte addresses; lane i at bits [32i+31:32i] |
| reqSizeM1 | input | 128 | Per-lane access size minus one; lane i at bits [4i+3:4i] |
| segSel | input | 1 | Segment size select: 0 = 32 bytes, 1 = 128 bytes |
| outValid | output | 1 | Segment request valid |
| outReady | input | 1 | Consumer takes the segment request |
| outBase | output | 32 | Aligned segment base address |
| outMask | output | 32 | Lanes served by this segment |
| donePulse | output | 1 | Warp finished strobe |
| doneCount | output | 7 | Segments issued for the finished warp |

## Verification
The first segment request is valid in the cycle after acceptance. Each later one follows in the cycle after the previous handshake. `donePulse` arrives one cycle after the last handshake, or one cycle after acceptance for an empty warp, and `reqReady` returns one cycle after that. The bench drives every input and samples every output on the falling clock edge. It takes a request as transferred when it has seen `outValid` and has itself driven `outReady` high in that same half-cycle. It then requires the done strobe at exactly the next falling edge after the final transfer. In stall runs it holds `outReady` low on alternate cycles and compares base and mask one cycle later against the values it recorded.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic load;   // capture a new warp
    logic issue;  // current segment handed over; retire its lanes
  } coal_strobe_t;

  typedef enum logic {
    ST_IDLE,
    ST_ISSUE
  } coal_state_t;
endpackage

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SZ_W      = 4,
  parameter int SEG_SMALL = 32,
  parameter int SEG_LARGE = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  coal_strobe_t             strobe,
  input  logic [LANES-1:0]         reqActive,
  input  logic [LANES*ADDR_W-1:0]  reqAddr,
  input  logic [LANES*SZ_W-1:0]    reqSizeM1,
  input  logic                     segSel,
  output logic                     anyPending,
  output logic [ADDR_W-1:0]        selBase,
  output logic [LANES-1:0]         selMask
);
  localparam logic [ADDR_W-1:0] OFF_SMALL = ADDR_W'(SEG_SMALL - 1);
  localparam logic [ADDR_W-1:0] OFF_LARGE = ADDR_W'(SEG_LARGE - 1);

  logic [ADDR_W-1:0] alignKeep;
  logic [ADDR_W-1:0] loNext [LANES];
  logic [ADDR_W-1:0] hiNext [LANES];
  logic [ADDR_W-1:0] loBase [LANES];
  logic [ADDR_W-1:0] hiBase [LANES];
  logic [LANES-1:0]  crossNext;
  logic [LANES-1:0]  pendLo;
  logic [LANES-1:0]  pendHi;
  logic [LANES-1:0]  hitLo;
  logic [LANES-1:0]  hitHi;

  assign alignKeep = segSel ? ~OFF_LARGE : ~OFF_SMALL;

  // Per-lane segment bounds and match against the selected segment
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    logic [ADDR_W-1:0] laneLast;
    assign laneAddr     = reqAddr[g*ADDR_W +: ADDR_W];
    assign laneLast     = laneAddr + ADDR_W'(reqSizeM1[g*SZ_W +: SZ_W]);
    assign loNext[g]    = laneAddr & alignKeep;
    assign hiNext[g]    = laneLast & alignKeep;
    assign crossNext[g] = (loNext[g] != hiNext[g]);
    assign hitLo[g]     = pendLo[g] && (loBase[g] == selBase);
    assign hitHi[g]     = pendHi[g] && (hiBase[g] == selBase);
  end

  assign selMask    = hitLo | hitHi;
  assign anyPending = |(pendLo | pendHi);

  // Lowest lane with an outstanding segment picks the next base
  always_comb begin
    logic found;
    found   = 1'b0;
    selBase = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && (pendLo[i] || pendHi[i])) begin
        found   = 1'b1;
        selBase = pendLo[i] ? loBase[i] : hiBase[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < LANES; i++) begin
        loBase[i] <= loNext[i];
        hiBase[i] <= hiNext[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLo <= '0;
      pendHi <= '0;
    end else if (strobe.load) begin
      pendLo <= reqActive;
      pendHi <= reqActive & crossNext;
    end else if (strobe.issue) begin
      pendLo <= pendLo & ~hitLo;
      pendHi <= pendHi & ~hitHi;
    end
  end
endmodule

// File: rtl/coal_control.sv
module coal_control
  import coal_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             anyPending,
  input  logic             outReady,
  output logic             reqReady,
  output logic             outValid,
  output logic             donePulse,
  output logic [CNT_W-1:0] doneCount,
  output coal_strobe_t     strobe
);
  coal_state_t      state;
  logic [CNT_W-1:0] segCnt;

  assign reqReady     = (state == ST_IDLE);
  assign outValid     = (state == ST_ISSUE) && anyPending;
  assign donePulse    = (state == ST_ISSUE) && !anyPending;
  assign doneCount    = segCnt;
  assign strobe.load  = reqValid && reqReady;
  assign strobe.issue = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      segCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state  <= ST_ISSUE;
            segCnt <= '0;
          end
        end
        ST_ISSUE: begin
          if (strobe.issue) segCnt <= segCnt + 1'b1;
          if (donePulse)    state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SZ_W      = 4,
  parameter int SEG_SMALL = 32,
  parameter int SEG_LARGE = 128,
  localparam int CNT_W    = $clog2(2*LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*SZ_W-1:0]   reqSizeM1,
  input  logic                    segSel,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [ADDR_W-1:0]       outBase,
  output logic [LANES-1:0]        outMask,
  output logic                    donePulse,
  output logic [CNT_W-1:0]        doneCount
);
  coal_strobe_t strobe;
  logic         anyPending;

  coal_control #(.CNT_W(CNT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .anyPending (anyPending),
    .outReady   (outReady),
    .reqReady   (reqReady),
    .outValid   (outValid),
    .donePulse  (donePulse),
    .doneCount  (doneCount),
    .strobe     (strobe)
  );

  coal_datapath #(
    .LANES     (LANES),
    .ADDR_W    (ADDR_W),
    .SZ_W      (SZ_W),
    .SEG_SMALL (SEG_SMALL),
    .SEG_LARGE (SEG_LARGE)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqActive  (reqActive),
    .reqAddr    (reqAddr),
    .reqSizeM1  (reqSizeM1),
    .segSel     (segSel),
    .anyPending (anyPending),
    .selBase    (outBase),
    .selMask    (outMask)
  );
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 32,
  parameter int SEG_SMALL = 32,
  parameter int CNT_W     = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outBase,
  input logic [LANES-1:0]  outMask,
  input logic              donePulse,
  input logic [CNT_W-1:0]  doneCount
);
  localparam int LOW_BITS = $clog2(SEG_SMALL);

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);  // R1
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBase[LOW_BITS-1:0] == '0));  // R2
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (doneCount <= CNT_W'(2*LANES)));  // R3
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMask != '0));  // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBase) && $stable(outMask));  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse && reqReady);  // R10
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !outValid && !reqReady);  // R10
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES     (LANES),
  .ADDR_W    (ADDR_W),
  .SEG_SMALL (SEG_SMALL),
  .CNT_W     (CNT_W)
) i_chk (.*);

// File: tb/test_warp_coalescer.sv
`timescale 1ns/1ps
module test_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int SW    = 4;
  localparam int CW    = 7;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [LANES-1:0]  reqActive;
  logic [LANES*AW-1:0] reqAddr;
  logic [LANES*SW-1:0] reqSizeM1;
  logic              segSel;
  logic              outValid;
  logic              outReady;
  logic [AW-1:0]     outBase;
  logic [LANES-1:0]  outMask;
  logic              donePulse;
  logic [CW-1:0]     doneCount;

  always #2.5 clk = ~clk;  // 200 MHz

  warp_coalescer i_warp_coalescer (.*);

  int nChk = 0;
  int nBad = 0;

  // Lane stimulus and expected segment list
  logic [31:0] laneAddr [LANES];
  logic [3:0]  laneSz   [LANES];
  logic [31:0] laneAct;
  bit          useBig;
  logic [31:0] expBase [64];
  logic [31:0] expMask [64];
  int          expN;

  // Stimulus table: base, stride, size code, active lanes, segment select, segment count
  localparam int NV = 11;
  localparam logic [31:0] V_BASE   [NV] = '{32'h1000, 32'h1000, 32'h2004, 32'h0, 32'h101C, 32'h101C,
                                            32'h3000, 32'h5000, 32'h101F, 32'h1070, 32'h1071};
  localparam int          V_STRIDE [NV] = '{4, 4, 0, 32'h1000, 0, 0, 32'h100, -32, 1, 0, 0};
  localparam logic [3:0]  V_SZ     [NV] = '{4'd3, 4'd3, 4'd0, 4'd0, 4'd7, 4'd7, 4'd15, 4'd3, 4'd1, 4'd15, 4'd15};
  localparam logic [31:0] V_ACT    [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005, 32'hFFFF_FFFF,
                                            32'h0000_0003, 32'h0000_0001, 32'h0000_0001};
  localparam bit          V_BIG    [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int          V_CNT    [NV] = '{4, 1, 1, 32, 2, 1, 2, 32, 2, 1, 2};
  // rows: 0,1 R12 contiguous words; 2 R3 shared address; 3 R4 scattered single bytes;
  // 4 R5 crossing a 32-byte boundary; 5 R2 same lane in 128-byte mode; 6 R11 sparse active;
  // 7 R6 descending addresses; 8 R7 crossing lane shares with neighbour;
  // 9 R5 ends on the last byte of a segment; 10 R5 one byte past it

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setWarp(logic [31:0] base, int stride, logic [3:0] sz, logic [31:0] act, bit big);
    for (int i = 0; i < LANES; i++) begin
      laneAddr[i] = base + 32'(i * stride);
      laneSz[i]   = sz;
    end
    laneAct = act;
    useBig  = big;
  endtask

  // Ordered list of segments by first touching lane, then the lanes each one serves
  task automatic buildModel();
    int sh;
    logic [31:0] lo, hi, s;
    bit seen;
    sh   = useBig ? 7 : 5;
    expN = 0;
    for (int i = 0; i < LANES; i++) begin
      if (laneAct[i]) begin
        lo = (laneAddr[i] >> sh) << sh;
        hi = ((laneAddr[i] + 32'(laneSz[i])) >> sh) << sh;
        for (int k = 0; k < 2; k++) begin
          s = (k == 0) ? lo : hi;
          if (!(k == 1 && hi == lo)) begin
            seen = 1'b0;
            for (int e = 0; e < expN; e++) if (expBase[e] == s) seen = 1'b1;
            if (!seen) begin
              expBase[expN] = s;
              expMask[expN] = '0;
              expN++;
            end
          end
        end
      end
    end
    for (int e = 0; e < expN; e++) begin
      for (int i = 0; i < LANES; i++) begin
        if (laneAct[i]) begin
          lo = (laneAddr[i] >> sh) << sh;
          hi = ((laneAddr[i] + 32'(laneSz[i])) >> sh) << sh;
          if (lo == expBase[e] || hi == expBase[e]) expMask[e][i] = 1'b1;
        end
      end
    end
  endtask

  task automatic runWarp(bit stall, int expCount);
    int idx;
    bit held, lastHs, doneSeen, rdy;
    logic [31:0] heldBase, heldMask;
    buildModel();
    @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      reqAddr[i*AW +: AW]   = laneAddr[i];
      reqSizeM1[i*SW +: SW] = laneSz[i];
    end
    reqActive = laneAct;
    segSel    = useBig;
    reqValid  = 1'b1;
    check(reqReady == 1'b1, "R1", "ready before accept", longint'(reqReady), 1);
    @(negedge clk);
    reqValid  = 1'b0;
    // Scramble inputs: only the accepted warp may matter (R2)
    reqAddr   = '1;
    reqSizeM1 = '1;
    reqActive = '1;
    segSel    = ~useBig;
    check(reqReady == 1'b0, "R1", "ready after accept", longint'(reqReady), 0);
    idx = 0; held = 0; lastHs = 0; doneSeen = 0;
    for (int c = 0; c < 400; c++) begin
      if (donePulse) begin
        check(doneCount == CW'(expCount), "R10", "done count", longint'(doneCount), expCount);
        check(idx == expN, "R3", "segments seen", idx, expN);
        if (expN == 0) check(c == 0, "R9", "empty warp done cycle", c, 0);
        else check(lastHs, "R10", "done right after last transfer", longint'(lastHs), 1);
        doneSeen = 1;
        break;
      end
      if (outValid) begin
        if (held) begin
          check(outBase == heldBase, "R8", "base held in stall", outBase, heldBase);
          check(outMask == heldMask, "R8", "mask held in stall", outMask, heldMask);
        end
        rdy = stall ? ((c % 2) == 1) : 1'b1;
        outReady = rdy;
        if (rdy) begin
          if (idx < 64) begin
            check(outBase == expBase[idx], "R6", "segment base", outBase, expBase[idx]);
            check(outMask == expMask[idx], "R7", "lane mask", outMask, expMask[idx]);
          end
          idx++;
          held = 0; lastHs = 1;
        end else begin
          held = 1; heldBase = outBase; heldMask = outMask; lastHs = 0;
        end
      end else begin
        check(1'b0, "R10", "neither valid nor done while busy", 0, 1);
        lastHs = 0;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    if (!doneSeen) check(1'b0, "R10", "done strobe missing", 0, 1);
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after done", longint'(reqReady), 1);
    check(donePulse == 1'b0, "R10", "done lasts one cycle", longint'(donePulse), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R10 watchdog expired: actual 0x0 expected 0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqActive = '0; reqAddr = '0;
    reqSizeM1 = '0; segSel = 1'b0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset ready", longint'(reqReady), 1);
    check(outValid == 1'b0, "R8", "reset valid", longint'(outValid), 0);
    check(donePulse == 1'b0, "R10", "reset done", longint'(donePulse), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      setWarp(V_BASE[v], V_STRIDE[v], V_SZ[v], V_ACT[v], V_BIG[v]);
      runWarp(1'b0, V_CNT[v]);
    end

    // R9: nothing active
    setWarp(32'h7000, 4, 4'd3, 32'h0, 1'b0);
    runWarp(1'b0, 0);

    // R8: consumer stalls every other cycle
    setWarp(32'h0, 32'h40, 4'd0, 32'hFFFF_FFFF, 1'b0);
    runWarp(1'b1, 32);
    setWarp(32'h1000, 4, 4'd3, 32'hFFFF_FFFF, 1'b0);
    runWarp(1'b1, 4);

    // R4: one isolated single-byte lane among shared ones
    setWarp(32'h2000, 0, 4'd0, 32'hFFFF_FFFF, 1'b1);
    laneAddr[17] = 32'h9000;
    runWarp(1'b0, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule